// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block holds a small byte-wide control register space behind a two-address I/O window. Software writes a register index to the index port, then makes one read or one write at the data port to reach the selected register. Each index write allows exactly one data-port access. Any other bus access in between discards the pending index, so the index write and the data access act as one uninterrupted pair.

The space has a bank of writable configuration registers and two read-only identification registers (a type code and a revision code). The identification registers can only be read while a 4-bit key field in one configuration register holds one exact value. Indexes that are not implemented, and identification registers whose key is not open, read as FFh, and writes to them change nothing. Read data comes back combinationally in the cycle of the read strobe. A write takes effect at the clock edge that samples the write strobe.

Top module: `cfgspace_port`

## Requirements
- R1: After synchronous reset every configuration register reads 00h and no index is pending, so a data-port read with no index write before it returns FFh.
- R2: A write to the index port (address 0022h) followed by a write to the data port (address 0023h) stores the data byte in the configuration register at that index, and a later index-write/data-read pair returns it.
- R3: Each index write allows one data-port access only. A second data-port write without a new index write is dropped, and a second data-port read returns FFh.
- R4: Any bus access other than the index write (a read or write at another address, or a read of the index port) between the index write and the data access cancels the pending index. Cycles with no strobe do not cancel it.
- R5: A read of an index outside the configuration bank and the identification indexes returns FFh. A write to such an index leaves every configuration register unchanged.
- R6: While bits 7:4 of the configuration register at index C3h equal 0001b, a read of index FEh returns the type-code parameter and a read of index FFh returns the revision-code parameter. Bits 3:0 of C3h have no effect on this.
- R7: While bits 7:4 of C3h hold any value other than 0001b, reads of FEh and FFh return FFh.
- R8: The identification registers are read-only. A data-port write to FEh or FFh does not change the value they read back.
- R9: io_rdata is FFh whenever io_rd is low, and so is a read of any address other than the data port. A data-port read returns its value in the same cycle as the strobe.
- R10: All eight bits of every configuration register (indexes C0h to C3h by default) are writable, including bit 2 of C2h and the key field of C3h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | ADDR_W (16) | I/O address of the current bus cycle |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |

## Verification
The bench builds the block with a bank of four configuration registers based at C0h, so the key register C3h and bit 2 of C2h fall inside the bank and C4h lies just past its end, which tests the unimplemented-index path at the bank's edge. It sets the identification values to A7h and 3Ch. These differ from FFh and from each other, so an open read, a blocked read and a swapped pair of identification registers each give a different result. The key field is driven through several closed values, including ones that match 0001b in only some bits, and through an open value with the low nibble set.

// File: rtl/cfgspace_pkg.sv
package cfgspace_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] cfg_byte_t;

    localparam cfg_byte_t FLOAT_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_IDX_WR,
        ACC_DATA_RD,
        ACC_DATA_WR,
        ACC_OTHER
    } acc_kind_t;

    typedef struct packed {
        cfg_byte_t idx;
        logic      vld;
    } idx_state_t;

    typedef struct packed {
        logic      hit;
        cfg_byte_t val;
    } rd_src_t;

    function automatic cfg_byte_t pick_src(rd_src_t first, rd_src_t second);
        if (first.hit)
            return first.val;
        else if (second.hit)
            return second.val;
        else
            return FLOAT_BYTE;
    endfunction

    function automatic logic key_match(logic [3:0] field, logic [3:0] want);
        return field == want;
    endfunction

endpackage

// File: rtl/cfgspace_decode.sv
module cfgspace_decode
    import cfgspace_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] IDX_PORT  = 16'h0022,
    parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0023
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    output acc_kind_t         kind
);

    logic at_idx;
    logic at_data;

    assign at_idx  = (io_addr == IDX_PORT);
    assign at_data = (io_addr == DATA_PORT);

    always_comb begin
        if (io_wr && at_idx)
            kind = ACC_IDX_WR;
        else if (io_wr && at_data)
            kind = ACC_DATA_WR;
        else if (io_rd && at_data)
            kind = ACC_DATA_RD;
        else if (io_rd || io_wr)
            kind = ACC_OTHER;
        else
            kind = ACC_NONE;
    end

endmodule

// File: rtl/cfgspace_index.sv
module cfgspace_index
    import cfgspace_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  acc_kind_t  kind,
    input  cfg_byte_t  io_wdata,
    output idx_state_t st,
    output logic       sel_wr,
    output logic       sel_rd
);

    idx_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{idx: '0, vld: 1'b0};
        end else begin
            case (kind)
                ACC_IDX_WR: st_q <= '{idx: io_wdata, vld: 1'b1};
                ACC_NONE:   st_q <= st_q;
                default:    st_q.vld <= 1'b0;
            endcase
        end
    end

    assign st     = st_q;
    assign sel_wr = st_q.vld && (kind == ACC_DATA_WR);
    assign sel_rd = st_q.vld && (kind == ACC_DATA_RD);

endmodule

// File: rtl/cfgspace_regs.sv
module cfgspace_regs
    import cfgspace_pkg::*;
#(
    parameter int        NUM_CFG     = 4,
    parameter cfg_byte_t CFG_BASE    = 8'hC0,
    parameter cfg_byte_t KEY_REG_IDX = 8'hC3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_wr,
    input  cfg_byte_t  idx,
    input  cfg_byte_t  io_wdata,
    output rd_src_t    src,
    output logic [3:0] map_key
);

    localparam int KEY_SLOT = int'(KEY_REG_IDX) - int'(CFG_BASE);

    cfg_byte_t        cfg_q [NUM_CFG];
    logic [NUM_CFG-1:0] slot_hit;

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_slot
        localparam cfg_byte_t SLOT_IDX = cfg_byte_t'(int'(CFG_BASE) + g);

        assign slot_hit[g] = (idx == SLOT_IDX);

        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[g] <= '0;
            else if (sel_wr && slot_hit[g])
                cfg_q[g] <= io_wdata;
        end
    end

    always_comb begin
        src = '{hit: 1'b0, val: FLOAT_BYTE};
        for (int k = 0; k < NUM_CFG; k++) begin
            if (slot_hit[k]) begin
                src.hit = 1'b1;
                src.val = cfg_q[k];
            end
        end
    end

    assign map_key = cfg_q[KEY_SLOT][7:4];

endmodule

// File: rtl/cfgspace_id.sv
module cfgspace_id
    import cfgspace_pkg::*;
#(
    parameter cfg_byte_t  ID0_IDX  = 8'hFE,
    parameter cfg_byte_t  ID1_IDX  = 8'hFF,
    parameter cfg_byte_t  ID0_VAL  = 8'h31,
    parameter cfg_byte_t  ID1_VAL  = 8'h52,
    parameter logic [3:0] KEY_OPEN = 4'h1
) (
    input  cfg_byte_t  idx,
    input  logic [3:0] map_key,
    output rd_src_t    src
);

    logic open;

    assign open = key_match(map_key, KEY_OPEN);

    always_comb begin
        src = '{hit: 1'b0, val: FLOAT_BYTE};
        if (open) begin
            if (idx == ID0_IDX)
                src = '{hit: 1'b1, val: ID0_VAL};
            else if (idx == ID1_IDX)
                src = '{hit: 1'b1, val: ID1_VAL};
        end
    end

endmodule

// File: rtl/cfgspace_port.sv
module cfgspace_port
    import cfgspace_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] IDX_PORT    = 16'h0022,
    parameter logic [ADDR_W-1:0] DATA_PORT   = 16'h0023,
    parameter int                NUM_CFG     = 4,
    parameter logic [7:0]        CFG_BASE    = 8'hC0,
    parameter logic [7:0]        KEY_REG_IDX = 8'hC3,
    parameter logic [7:0]        ID0_IDX     = 8'hFE,
    parameter logic [7:0]        ID1_IDX     = 8'hFF,
    parameter logic [7:0]        ID0_VAL     = 8'h31,
    parameter logic [7:0]        ID1_VAL     = 8'h52,
    parameter logic [3:0]        KEY_OPEN    = 4'h1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata
);

    acc_kind_t  kind;
    idx_state_t idx_st;
    logic       sel_wr;
    logic       sel_rd;
    rd_src_t    cfg_src;
    rd_src_t    id_src;
    logic [3:0] map_key;
    cfg_byte_t  cur_idx;
    logic       cur_vld;

    cfgspace_decode #(
        .ADDR_W   (ADDR_W),
        .IDX_PORT (IDX_PORT),
        .DATA_PORT(DATA_PORT)
    ) u_decode (
        .io_addr(io_addr),
        .io_rd  (io_rd),
        .io_wr  (io_wr),
        .kind   (kind)
    );

    cfgspace_index u_index (
        .clk     (clk),
        .rst     (rst),
        .kind    (kind),
        .io_wdata(io_wdata),
        .st      (idx_st),
        .sel_wr  (sel_wr),
        .sel_rd  (sel_rd)
    );

    assign cur_idx = idx_st.idx;
    assign cur_vld = idx_st.vld;

    cfgspace_regs #(
        .NUM_CFG    (NUM_CFG),
        .CFG_BASE   (CFG_BASE),
        .KEY_REG_IDX(KEY_REG_IDX)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .sel_wr  (sel_wr),
        .idx     (cur_idx),
        .io_wdata(io_wdata),
        .src     (cfg_src),
        .map_key (map_key)
    );

    cfgspace_id #(
        .ID0_IDX (ID0_IDX),
        .ID1_IDX (ID1_IDX),
        .ID0_VAL (ID0_VAL),
        .ID1_VAL (ID1_VAL),
        .KEY_OPEN(KEY_OPEN)
    ) u_id (
        .idx    (cur_idx),
        .map_key(map_key),
        .src    (id_src)
    );

    assign io_rdata = sel_rd ? pick_src(cfg_src, id_src) : FLOAT_BYTE;

endmodule

// File: rtl/cfgspace_checker.sv
module cfgspace_checker #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] IDX_PORT  = 16'h0022,
    parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0023,
    parameter logic [7:0]        ID0_IDX   = 8'hFE,
    parameter logic [7:0]        ID1_IDX   = 8'hFF,
    parameter logic [7:0]        ID0_VAL   = 8'h31,
    parameter logic [7:0]        ID1_VAL   = 8'h52,
    parameter logic [3:0]        KEY_OPEN  = 4'h1
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_rd,
    input logic              io_wr,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic [7:0]        cur_idx,
    input logic              cur_vld,
    input logic [3:0]        map_key
);

    logic data_acc;
    logic data_rd;
    logic idx_load;
    logic id_rd;

    assign data_acc = (io_rd || io_wr) && (io_addr == DATA_PORT);
    assign data_rd  = io_rd && !io_wr && (io_addr == DATA_PORT);
    assign idx_load = io_wr && (io_addr == IDX_PORT);
    assign id_rd    = data_rd && cur_vld && ((cur_idx == ID0_IDX) || (cur_idx == ID1_IDX));

    AST_RESET_DROPS_INDEX: assert property (@(posedge clk) rst |=> !cur_vld); // R1

    AST_INDEX_LOADS: assert property (@(posedge clk) disable iff (rst)
        idx_load |=> (cur_vld && cur_idx == $past(io_wdata))); // R2

    AST_ONE_ACCESS_PER_INDEX: assert property (@(posedge clk) disable iff (rst)
        data_acc |=> (!data_rd || io_rdata == 8'hFF)); // R3

    AST_FOREIGN_ACCESS_CANCELS: assert property (@(posedge clk) disable iff (rst)
        ((io_rd || io_wr) && !data_acc && !idx_load) |=> (!data_rd || io_rdata == 8'hFF)); // R4

    AST_ID0_OPEN_VALUE: assert property (@(posedge clk) disable iff (rst)
        (id_rd && cur_idx == ID0_IDX && map_key == KEY_OPEN) |-> io_rdata == ID0_VAL); // R6

    AST_ID1_OPEN_VALUE: assert property (@(posedge clk) disable iff (rst)
        (id_rd && cur_idx == ID1_IDX && map_key == KEY_OPEN) |-> io_rdata == ID1_VAL); // R6

    AST_ID_BLOCKED_FLOATS: assert property (@(posedge clk) disable iff (rst)
        (id_rd && map_key != KEY_OPEN) |-> io_rdata == 8'hFF); // R7

    AST_IDLE_FLOATS: assert property (@(posedge clk) disable iff (rst)
        !io_rd |-> io_rdata == 8'hFF); // R9

endmodule

bind cfgspace_port cfgspace_checker #(
    .ADDR_W   (ADDR_W),
    .IDX_PORT (IDX_PORT),
    .DATA_PORT(DATA_PORT),
    .ID0_IDX  (ID0_IDX),
    .ID1_IDX  (ID1_IDX),
    .ID0_VAL  (ID0_VAL),
    .ID1_VAL  (ID1_VAL),
    .KEY_OPEN (KEY_OPEN)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .io_addr (io_addr),
    .io_rd   (io_rd),
    .io_wr   (io_wr),
    .io_wdata(io_wdata),
    .io_rdata(io_rdata),
    .cur_idx (cur_idx),
    .cur_vld (cur_vld),
    .map_key (map_key)
);

// File: tb/cfgspace_port_bench.sv
module cfgspace_port_bench;

    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] IDXP       = 16'h0022;
    localparam logic [15:0] DATP       = 16'h0023;
    localparam logic [7:0]  ID0        = 8'hA7;
    localparam logic [7:0]  ID1        = 8'h3C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgspace_port #(
        .NUM_CFG(4),
        .CFG_BASE(8'hC0),
        .KEY_REG_IDX(8'hC3),
        .ID0_VAL(ID0),
        .ID1_VAL(ID1)
    ) u_cfgspace_port (
        .clk     (clk),
        .rst     (rst),
        .io_addr (io_addr),
        .io_rd   (io_rd),
        .io_wr   (io_wr),
        .io_wdata(io_wdata),
        .io_rdata(io_rdata)
    );

    task automatic cyc(input logic [15:0] a, input logic r, input logic w, input logic [7:0] d);
        @(negedge clk);
        io_addr  = a;
        io_rd    = r;
        io_wr    = w;
        io_wdata = d;
    endtask

    task automatic idle();
        cyc(16'h0000, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic expect_at(input logic [15:0] a, input logic [7:0] e, input string t);
        sb.push_back('{exp: e, tag: t});
        cyc(a, 1'b1, 1'b0, 8'h00);
    endtask

    task automatic rd_reg(input logic [7:0] idx, input logic [7:0] e, input string t);
        cyc(IDXP, 1'b0, 1'b1, idx);
        expect_at(DATP, e, t);
    endtask

    task automatic wr_reg(input logic [7:0] idx, input logic [7:0] v);
        cyc(IDXP, 1'b0, 1'b1, idx);
        cyc(DATP, 1'b0, 1'b1, v);
    endtask

    task automatic check_idle(input string t);
        idle();
        #(CLK_PERIOD/4);
        checks++;
        if (io_rdata !== 8'hFF) begin
            fails++;
            $display("FAIL %s: rdata=%h expected ff", t, io_rdata);
        end
    endtask

    // monitor: pops one expected item for each read strobe it sees
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (io_rd && !rst) begin
                checks++;
                if (sb.size() == 0) begin
                    fails++;
                    $display("FAIL scoreboard R9: read with no expected item, rdata=%h expected none", io_rdata);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    if (io_rdata !== it.exp) begin
                        fails++;
                        $display("FAIL %s: rdata=%h expected %h", it.tag, io_rdata, it.exp);
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        expect_at(DATP, 8'hFF, "R1 data read with no index after reset");
        rd_reg(8'hC0, 8'h00, "R1 C0 after reset");
        rd_reg(8'hC1, 8'h00, "R1 C1 after reset");
        rd_reg(8'hC2, 8'h00, "R1 C2 after reset");
        rd_reg(8'hC3, 8'h00, "R1 C3 after reset");
        rd_reg(8'hFE, 8'hFF, "R7 type code blocked after reset");

        // R9: idle and non-data reads float
        check_idle("R9 idle bus");
        expect_at(16'h0080, 8'hFF, "R9 read of foreign address");

        // R2 / R10: full-byte writes
        wr_reg(8'hC2, 8'h04);
        rd_reg(8'hC2, 8'h04, "R10 C2 bit 2");
        wr_reg(8'hC0, 8'hA5);
        wr_reg(8'hC1, 8'h5A);
        rd_reg(8'hC0, 8'hA5, "R2 C0 write/readback");
        rd_reg(8'hC1, 8'h5A, "R2 C1 write/readback");
        wr_reg(8'hC3, 8'hF0);
        rd_reg(8'hC3, 8'hF0, "R10 C3 key field");
        wr_reg(8'hC2, 8'hFF);
        rd_reg(8'hC2, 8'hFF, "R10 C2 all bits");

        // R3: one access per index
        wr_reg(8'hC1, 8'h11);
        cyc(DATP, 1'b0, 1'b1, 8'h22);
        rd_reg(8'hC1, 8'h11, "R3 second write dropped");
        cyc(IDXP, 1'b0, 1'b1, 8'hC1);
        expect_at(DATP, 8'h11, "R3 first read");
        expect_at(DATP, 8'hFF, "R3 second read floats");

        // R4: cancellation by foreign access, not by idle cycles
        cyc(IDXP, 1'b0, 1'b1, 8'hC0);
        cyc(16'h0080, 1'b0, 1'b1, 8'h00);
        cyc(DATP, 1'b0, 1'b1, 8'h77);
        rd_reg(8'hC0, 8'hA5, "R4 write after foreign write dropped");
        cyc(IDXP, 1'b0, 1'b1, 8'hC0);
        expect_at(IDXP, 8'hFF, "R4 index port read floats");
        expect_at(DATP, 8'hFF, "R4 read after index-port read floats");
        cyc(IDXP, 1'b0, 1'b1, 8'hC0);
        idle();
        idle();
        expect_at(DATP, 8'hA5, "R4 idle cycles keep index");

        // R5: unimplemented indexes
        wr_reg(8'h10, 8'h33);
        rd_reg(8'h10, 8'hFF, "R5 index 10h floats");
        wr_reg(8'hC4, 8'h44);
        rd_reg(8'hC4, 8'hFF, "R5 index C4h floats");
        rd_reg(8'hC0, 8'hA5, "R5 C0 untouched");
        rd_reg(8'hC1, 8'h11, "R5 C1 untouched");
        rd_reg(8'hC2, 8'hFF, "R5 C2 untouched");
        rd_reg(8'hC3, 8'hF0, "R5 C3 untouched");

        // R7: closed keys
        wr_reg(8'hC3, 8'h00);
        rd_reg(8'hFE, 8'hFF, "R7 key 0000 type code");
        wr_reg(8'hC3, 8'h30);
        rd_reg(8'hFE, 8'hFF, "R7 key 0011 type code");
        wr_reg(8'hC3, 8'h90);
        rd_reg(8'hFF, 8'hFF, "R7 key 1001 revision code");
        wr_reg(8'hC3, 8'h01);
        rd_reg(8'hFE, 8'hFF, "R7 key in low nibble only");

        // R6: open key
        wr_reg(8'hC3, 8'h10);
        rd_reg(8'hFE, ID0, "R6 type code open");
        rd_reg(8'hFF, ID1, "R6 revision code open");
        wr_reg(8'hC3, 8'h1F);
        rd_reg(8'hFE, ID0, "R6 type code, low nibble set");

        // R8: read-only identification
        wr_reg(8'hFE, 8'h00);
        rd_reg(8'hFE, ID0, "R8 type code after write");
        wr_reg(8'hFF, 8'h00);
        rd_reg(8'hFF, ID1, "R8 revision code after write");
        rd_reg(8'hC3, 8'h1F, "R8 key unchanged by ID writes");

        idle();
        idle();
        if (sb.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL scoreboard R9: %0d reads missing, expected 0", sb.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule